// File: doc/BRIEF.md
# Short/Long Instruction Parcel Unpacker

This block sits between an instruction fetch stream and a decoder. Fetch hands it fixed 30-bit parcels. Each parcel carries either one 30-bit (long) instruction or two 15-bit (short) instructions. A long instruction is never split across two parcels. When a long instruction would otherwise straddle a boundary, the code generator fills the gap with a short no-op. The unpacker reads the opcode of each half, looks up the instruction length in a parameterised table, and hands the instructions to the decoder one at a time. Each instruction carries a flag that says whether it is long.

Both sides use valid/ready handshakes. A parcel is taken only when every instruction of the previous parcel has left the block. The upper half of a parcel is always examined first. The lower half is used only when the upper half turns out to be short. A long opcode found in the lower half breaks the packing rule. The block still passes that half on as a short instruction, but it raises an alignment-error flag with it. The `dropNopEn` input removes padding no-ops from the output stream, so the decoder never spends a slot on them.

Top module: `parcel_unpack`

## Requirements
- R1: After reset, `inReady` is 1 and `outValid` is 0.
- R2: The opcode of a half is its top 6 bits, so bits [14:9] of the half. With the default table, opcodes 48 to 63 are long and opcodes 0 to 47 are short. The no-op opcode is 0.
- R3: If the upper half (parcel bits [29:15]) has a long opcode, the whole parcel is emitted as one instruction with `outLong` = 1. Nothing else from that parcel is emitted.
- R4: If the upper half is short, it is emitted first and the lower half follows. Each short instruction appears on `outInstr[14:0]`, with `outInstr[29:15]` = 0 and `outLong` = 0.
- R5: A lower half with a long opcode is emitted as a short instruction with `outAlignErr` = 1. Every other emitted instruction has `outAlignErr` = 0.
- R6: With `dropNopEn` = 1, short halves with opcode 0 are not emitted. With `dropNopEn` = 0, they are emitted like any other short instruction.
- R7: `inReady` is 0 from the cycle after a parcel is accepted until all of that parcel's instructions have been emitted. The `inParcel` value is not sampled during that time.
- R8: While `outValid` is 1 and `outReady` is 0, `outInstr`, `outLong` and `outAlignErr` hold their values and `outValid` stays 1.
- R9: `inReady` becomes 1 in the cycle after the last instruction's handshake. When a trailing lower no-op is dropped, this happens one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dropNopEn | input | 1 | Remove short no-op halves from the output |
| inValid | input | 1 | Parcel offered |
| inReady | output | 1 | Parcel can be taken |
| inParcel | input | 30 | Instruction parcel |
| outValid | output | 1 | Instruction offered |
| outReady | input | 1 | Decoder takes the instruction |
| outInstr | output | 30 | Instruction; short ones right-aligned |
| outLong | output | 1 | Instruction is 30 bits long |
| outAlignErr | output | 1 | Long opcode found in a lower half |

## Verification
The hardest cases to reach from the ports are those where dropping and back-pressure combine. One such case is an upper half that is emitted while its lower no-op is dropped. This inserts a silent cycle before the block is ready again. Another is a fully dropped parcel, which produces no output at all. To reach them, the bench sweeps every upper opcode against a set of lower opcodes, with dropping off and on. These lower opcodes include the no-op, the last short opcode and both ends of the long range. Throughout the sweep, `outReady` is throttled on a fixed pattern, and the expected count, order, flags and ready timing are computed for each parcel.

// File: rtl/parcel_unpack_pkg.sv
package parcel_unpack_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_HI    = 2'd1,
    ST_LO    = 2'd2
  } unpackState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadParcel;
    logic selLow;
  } dpStrobe_t;

  // length/no-op status from datapath to control
  typedef struct packed {
    logic hiLong;
    logic hiNop;
    logic loLong;
    logic loNop;
  } dpStatus_t;

endpackage

// File: rtl/parcel_unpack_dp.sv
module parcel_unpack_dp
  import parcel_unpack_pkg::*;
#(
  parameter int HALF_W = 15,
  parameter int OPC_W  = 6,
  parameter logic [(1<<OPC_W)-1:0] LONG_MASK = '1 << (3 * (1 << OPC_W) / 4),
  parameter int NOP_OPC = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [2*HALF_W-1:0] inParcel,
  output dpStatus_t           status,
  output logic [2*HALF_W-1:0] outInstr,
  output logic                outLong,
  output logic                outAlignErr
);

  localparam int PARCEL_W = 2 * HALF_W;
  localparam logic [OPC_W-1:0] NOP_CODE = OPC_W'(NOP_OPC);

  logic [PARCEL_W-1:0] parcelQ;
  logic [HALF_W-1:0]   hiHalf;
  logic [HALF_W-1:0]   loHalf;
  logic [OPC_W-1:0]    hiOpc;
  logic [OPC_W-1:0]    loOpc;
  logic                hiIsLong;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parcelQ <= '0;
    end else if (strobe.loadParcel) begin
      parcelQ <= inParcel;
    end
  end

  assign hiHalf = parcelQ[PARCEL_W-1:HALF_W];
  assign loHalf = parcelQ[HALF_W-1:0];
  assign hiOpc  = hiHalf[HALF_W-1 -: OPC_W];
  assign loOpc  = loHalf[HALF_W-1 -: OPC_W];

  // length table lookup
  assign hiIsLong = LONG_MASK[hiOpc];

  always_comb begin
    status.hiLong = hiIsLong;
    status.hiNop  = (hiOpc == NOP_CODE) && !hiIsLong;
    status.loLong = LONG_MASK[loOpc];
    status.loNop  = (loOpc == NOP_CODE) && !LONG_MASK[loOpc];
  end

  always_comb begin
    outLong     = !strobe.selLow && hiIsLong;
    outAlignErr = strobe.selLow && status.loLong;
    if (outLong) begin
      outInstr = parcelQ;
    end else begin
      outInstr = {{HALF_W{1'b0}}, (strobe.selLow ? loHalf : hiHalf)};
    end
  end

endmodule

// File: rtl/parcel_unpack_ctrl.sv
module parcel_unpack_ctrl
  import parcel_unpack_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      dropNopEn,
  input  logic      inValid,
  output logic      inReady,
  output logic      outValid,
  input  logic      outReady,
  input  dpStatus_t status,
  output dpStrobe_t strobe
);

  unpackState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_EMPTY;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext         = state;
    inReady           = 1'b0;
    outValid          = 1'b0;
    strobe.loadParcel = 1'b0;
    strobe.selLow     = (state == ST_LO);
    unique case (state)
      ST_EMPTY: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.loadParcel = 1'b1;
          stateNext         = ST_HI;
        end
      end
      ST_HI: begin
        if (status.hiLong) begin
          outValid = 1'b1;
          if (outReady) stateNext = ST_EMPTY;
        end else if (dropNopEn && status.hiNop) begin
          stateNext = ST_LO;
        end else begin
          outValid = 1'b1;
          if (outReady) stateNext = ST_LO;
        end
      end
      ST_LO: begin
        if (dropNopEn && status.loNop) begin
          stateNext = ST_EMPTY;
        end else begin
          outValid = 1'b1;
          if (outReady) stateNext = ST_EMPTY;
        end
      end
      default: stateNext = ST_EMPTY;
    endcase
  end

  // R7
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (inReady && !outValid));

endmodule

// File: rtl/parcel_unpack.sv
module parcel_unpack
  import parcel_unpack_pkg::*;
#(
  parameter int HALF_W = 15,
  parameter int OPC_W  = 6,
  parameter logic [(1<<OPC_W)-1:0] LONG_MASK = '1 << (3 * (1 << OPC_W) / 4),
  parameter int NOP_OPC = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dropNopEn,
  input  logic                inValid,
  output logic                inReady,
  input  logic [2*HALF_W-1:0] inParcel,
  output logic                outValid,
  input  logic                outReady,
  output logic [2*HALF_W-1:0] outInstr,
  output logic                outLong,
  output logic                outAlignErr
);

  dpStrobe_t strobe;
  dpStatus_t status;

  parcel_unpack_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dropNopEn(dropNopEn),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .status   (status),
    .strobe   (strobe)
  );

  parcel_unpack_dp #(
    .HALF_W   (HALF_W),
    .OPC_W    (OPC_W),
    .LONG_MASK(LONG_MASK),
    .NOP_OPC  (NOP_OPC)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inParcel   (inParcel),
    .status     (status),
    .outInstr   (outInstr),
    .outLong    (outLong),
    .outAlignErr(outAlignErr)
  );

  // R8
  stable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outInstr)
                                 && $stable(outLong) && $stable(outAlignErr)));

  // R4
  short_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLong) |-> (outInstr[2*HALF_W-1:HALF_W] == '0));

  // R6
  drop_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && dropNopEn && !outLong && !outAlignErr)
      |-> (outInstr[HALF_W-1 -: OPC_W] != OPC_W'(NOP_OPC)));

  // R9
  ready_after_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLong) |=> inReady);

  // R3
  long_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLong |-> !outAlignErr);

endmodule

// File: tb/test_parcel_unpack.sv
module test_parcel_unpack;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dropNopEn = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [29:0] inParcel = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [29:0] outInstr;
  logic        outLong;
  logic        outAlignErr;

  int compared = 0;
  int mismatched = 0;
  int stepCnt = 0;

  parcel_unpack i_parcel_unpack (
    .clk(clk), .rstN(rstN), .dropNopEn(dropNopEn),
    .inValid(inValid), .inReady(inReady), .inParcel(inParcel),
    .outValid(outValid), .outReady(outReady), .outInstr(outInstr),
    .outLong(outLong), .outAlignErr(outAlignErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  function automatic bit isLongOpc(input logic [5:0] opc);
    return opc >= 6'd48;  // R2 default table
  endfunction

  task automatic runParcel(input logic [5:0] hiOpc, input logic [5:0] loOpc,
                           input logic drop);
    logic [14:0] hiHalf, loHalf;
    logic [29:0] parcel;
    logic [29:0] eI[2];
    bit eL[2], eE[2];
    int n, got, postCnt, need;
    bit loDropped;
    hiHalf = {hiOpc, 9'((int'(hiOpc) * 5 + 3) % 512)};
    loHalf = {loOpc, 9'((int'(loOpc) * 11 + 1) % 512)};
    parcel = {hiHalf, loHalf};
    n = 0;
    loDropped = 1'b0;
    if (isLongOpc(hiOpc)) begin
      eI[0] = parcel; eL[0] = 1'b1; eE[0] = 1'b0; n = 1;
    end else begin
      if (!(drop && hiOpc == 6'd0)) begin
        eI[n] = {15'b0, hiHalf}; eL[n] = 1'b0; eE[n] = 1'b0; n++;
      end
      if (!(drop && loOpc == 6'd0)) begin
        eI[n] = {15'b0, loHalf}; eL[n] = 1'b0; eE[n] = isLongOpc(loOpc); n++;
      end else begin
        loDropped = 1'b1;
      end
    end
    // trailing dropped lower no-op costs one silent cycle (R9)
    need = (loDropped && n > 0) ? 2 : 1;

    dropNopEn = drop;
    inValid   = 1'b1;
    inParcel  = parcel;
    outReady  = 1'b0;
    #1;
    chk(inReady, "R7 ready before accept", 32'(inReady), 32'h1);
    @(negedge clk);
    inValid  = 1'b0;
    inParcel = ~parcel;  // must not be picked up (R7)
    got = 0;
    postCnt = 0;
    for (int c = 0; c < 40; c++) begin
      outReady = ((stepCnt % 4) != 2);
      stepCnt++;
      #1;
      if (got == n && n > 0) begin
        postCnt++;
        if (postCnt == need) begin
          chk(inReady && !outValid, "R9 ready after last instruction",
              32'({inReady, outValid}), 32'h2);
          break;
        end
      end
      if (n == 0 && inReady) break;
      if (got < n) begin
        chk(!inReady, "R7 busy while instructions pending", 32'(inReady), 32'h0);
      end
      if (outValid && outReady && got < n) begin
        chk(outInstr == eI[got], "R4 R3 instruction value", 32'(outInstr), 32'(eI[got]));
        chk(outLong == eL[got], "R3 long flag", 32'(outLong), 32'(eL[got]));
        chk(outAlignErr == eE[got], "R5 alignment flag", 32'(outAlignErr), 32'(eE[got]));
        got++;
      end else if (outValid && got >= n) begin
        chk(1'b0, "R6 extra instruction emitted", 32'(outInstr), 32'h0);
      end
      @(negedge clk);
    end
    chk(got == n, "R6 instruction count", 32'(got), 32'(n));
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R7 watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [5:0] loList[6];
    loList = '{6'd0, 6'd1, 6'd30, 6'd47, 6'd48, 6'd63};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(inReady == 1'b1, "R1 reset inReady", 32'(inReady), 32'h1);
    chk(outValid == 1'b0, "R1 reset outValid", 32'(outValid), 32'h0);
    @(negedge clk);
    // R2 sweep over every upper opcode
    for (int d = 0; d < 2; d++) begin
      for (int h = 0; h < 64; h++) begin
        for (int l = 0; l < 6; l++) begin
          runParcel(6'(h), loList[l], d[0]);
        end
      end
    end
    summary();
    $finish;
  end

endmodule